// File: doc/BRIEF.md
# Security-Aware Interrupt Priority File

This block keeps one 8-bit priority for each shared interrupt of an interrupt distributor. Software reaches it through a small request port. The port takes byte accesses, which touch one interrupt, and 32-bit word accesses, which touch four neighbouring interrupts at once. Every request carries a secure attribute. The block takes the group bitmap and the security-disable bit as inputs. From these it decides, for each interrupt, whether a request sees the raw stored byte, a non-secure view of it, or nothing at all.

Non-secure software works in a compressed priority space. Its writes are halved and forced into the upper half of the numeric range, which is the lower-priority half. Its reads are doubled back, so it sees its own values again. After any write that passes the range check, the block raises a one-cycle update strobe tagged with the word index. Downstream selection logic uses it to re-evaluate. The block does not select the highest-priority interrupt and does not route interrupts.

Top module: `prio_file`

## Requirements
- R1: After reset every stored priority is 0x00, and `rsp_valid` and `upd_valid` are low.
- R2: The byte address equals the interrupt number. A word access uses the address bits above [1:0] and places interrupt 4*w+k in data bits [8k+7:8k]. A byte read returns its value in bits [7:0] with bits [31:8] zero. A byte write takes `req_wdata[7:0]`.
- R3: A secure request, or any request while `sec_disable` is 1, reads and writes the stored byte unchanged.
- R4: A non-secure request while `sec_disable` is 0, to an interrupt whose group bit is 0, reads that field as zero and leaves it unchanged on a write.
- R5: A non-secure read of a group-1 interrupt while security is enabled returns the stored value shifted left by one, truncated to 8 bits.
- R6: A non-secure write to a group-1 interrupt while security is enabled stores 0x80 OR (written byte shifted right by one).
- R7: Interrupt numbers below 32, or at or above `NUM_IRQ`, read as zero and ignore writes.
- R8: A word write whose four interrupts are not all in the range 32 to `NUM_IRQ`-1 changes no field at all, including the fields that are in range.
- R9: One cycle after a write that passes the range checks of R7 and R8, `upd_valid` is 1 and `upd_word` equals the request address divided by 4. This holds even when R4 blocks the write. In every other cycle `upd_valid` is 0.
- R10: A read returns its data on `rsp_rdata` with `rsp_valid` high in the cycle after the request. `rsp_valid` is low in the cycle after a write or an idle cycle.
- R11: The group bitmap `grp1_map` bit i belongs to interrupt 32+i, where 1 means group 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit word access, 0 = byte access |
| req_secure | input | 1 | Secure attribute of the request |
| req_addr | input | ADDR_W (10) | Byte offset into the priority range |
| req_wdata | input | 32 | Write data |
| sec_disable | input | 1 | 1 = single security state, all requests see raw values |
| grp1_map | input | NUM_IRQ-32 (38) | Group bit per shared interrupt, bit i for interrupt 32+i |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| upd_valid | output | 1 | Update strobe after an accepted write |
| upd_word | output | ADDR_W-2 (8) | Word index the update refers to |

## Verification
The hardest case to reach from the ports is a word write that spans the implemented limit. Its low lanes are legal and its high lanes are not, so a lane-by-lane implementation would update only part of the word. The default count of 70 interrupts places the limit inside a word. The directed stimulus writes that straddling word, then reads the legal lanes back through single-byte accesses. The random phase draws addresses a few words past the limit and mixes secure and non-secure attributes against a shifting group bitmap. This makes non-secure writes to group-0 lanes (which still strobe but store nothing) meet the straddling-word rule in the same runs.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int FIRST_SHARED = 32;
    localparam int LANES        = 4;
    localparam int BYTE_W       = 8;
    localparam int WORD_W       = LANES * BYTE_W;

    typedef logic [BYTE_W-1:0] prio_t;

    // How one lane of a request reaches its stored field
    typedef enum logic [1:0] {
        VIEW_NONE = 2'd0,  // read zero, write ignored
        VIEW_RAW  = 2'd1,  // stored byte unchanged
        VIEW_NS   = 2'd2   // compressed non-secure view
    } view_e;

    typedef struct packed {
        logic  sel;       // lane takes part in this request
        logic  in_range;  // interrupt is an implemented shared one
        view_e view;      // access view after security policy
    } lane_ctl_t;

    function automatic prio_t ns_read_view(input prio_t stored);
        return {stored[BYTE_W-2:0], 1'b0};
    endfunction

    function automatic prio_t ns_write_view(input prio_t value);
        return {1'b1, value[BYTE_W-1:1]};
    endfunction

    function automatic view_e pick_view(input logic in_range,
                                        input logic restricted,
                                        input logic grp1);
        if (!in_range)        return VIEW_NONE;
        else if (!restricted) return VIEW_RAW;
        else if (grp1)        return VIEW_NS;
        else                  return VIEW_NONE;
    endfunction

endpackage

// File: rtl/prio_lane_dec.sv
module prio_lane_dec #(
    parameter int NUM_IRQ = 70,
    parameter int ADDR_W  = 10,
    parameter int LANE    = 0,
    parameter int IDX_W   = 6
) (
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              lane_sel,
    output logic              lane_in_range,
    output logic [IDX_W-1:0]  lane_idx
);
    import prio_pkg::*;

    logic [ADDR_W-1:0] irq;
    logic [ADDR_W-1:0] rel;

    always_comb begin
        irq           = {req_addr[ADDR_W-1:2], 2'(LANE)};
        lane_sel      = req_word || (req_addr[1:0] == 2'(LANE));
        lane_in_range = (int'(irq) >= FIRST_SHARED) && (int'(irq) < NUM_IRQ);
        rel           = irq - ADDR_W'(FIRST_SHARED);
        lane_idx      = lane_in_range ? rel[IDX_W-1:0] : '0;
    end

endmodule

// File: rtl/prio_store.sv
module prio_store #(
    parameter int DEPTH = 38,
    parameter int IDX_W = 6
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [prio_pkg::LANES-1:0]            we,
    input  logic [prio_pkg::LANES-1:0][IDX_W-1:0] idx,
    input  prio_pkg::prio_t [prio_pkg::LANES-1:0] wdata,
    output prio_pkg::prio_t [prio_pkg::LANES-1:0] rdata
);
    import prio_pkg::*;

    prio_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (we[l]) mem[idx[l]] <= wdata[l];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rdata[l] = (int'(idx[l]) < DEPTH) ? mem[idx[l]] : '0;
    end

    // R2: lanes of one request never collide on the same entry
    a_r2_distinct_lanes: assert property (@(posedge clk) disable iff (rst)
        (we[0] && we[1]) |-> (idx[0] != idx[1]));

endmodule

// File: rtl/prio_file.sv
module prio_file #(
    parameter int NUM_IRQ = 70,
    parameter int ADDR_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_word,
    input  logic                     req_secure,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [31:0]              req_wdata,
    input  logic                     sec_disable,
    input  logic [NUM_IRQ-33:0]      grp1_map,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    output logic                     upd_valid,
    output logic [ADDR_W-3:0]        upd_word
);
    import prio_pkg::*;

    localparam int SPI_CNT = NUM_IRQ - FIRST_SHARED;
    localparam int IDX_W   = (SPI_CNT > 1) ? $clog2(SPI_CNT) : 1;

    logic                         restricted;
    logic [LANES-1:0]             sel, in_rng, lane_we;
    logic [LANES-1:0][IDX_W-1:0]  idx;
    lane_ctl_t [LANES-1:0]        ctl;
    prio_t [LANES-1:0]            st_rd, st_wd, lane_rd;
    logic                         range_ok, wr_accept;
    logic [31:0]                  rd_mux;

    assign restricted = !req_secure && !sec_disable;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic grp_bit;

        prio_lane_dec #(
            .NUM_IRQ (NUM_IRQ),
            .ADDR_W  (ADDR_W),
            .LANE    (l),
            .IDX_W   (IDX_W)
        ) u_dec (
            .req_word      (req_word),
            .req_addr      (req_addr),
            .lane_sel      (sel[l]),
            .lane_in_range (in_rng[l]),
            .lane_idx      (idx[l])
        );

        assign grp_bit = (in_rng[l] && int'(idx[l]) < SPI_CNT) ? grp1_map[idx[l]] : 1'b0;

        always_comb begin
            ctl[l].sel      = sel[l];
            ctl[l].in_range = in_rng[l];
            ctl[l].view     = pick_view(in_rng[l], restricted, grp_bit);
        end

        always_comb begin
            unique case (ctl[l].view)
                VIEW_RAW: lane_rd[l] = st_rd[l];
                VIEW_NS:  lane_rd[l] = ns_read_view(st_rd[l]);
                default:  lane_rd[l] = '0;
            endcase
        end

        always_comb begin
            prio_t raw;
            raw      = req_word ? req_wdata[l*BYTE_W +: BYTE_W] : req_wdata[BYTE_W-1:0];
            st_wd[l] = (ctl[l].view == VIEW_NS) ? ns_write_view(raw) : raw;
        end

        assign lane_we[l] = wr_accept && ctl[l].sel && (ctl[l].view != VIEW_NONE);
    end

    // Range gate: a word needs all four lanes legal, a byte only its own
    assign range_ok  = req_word ? (&in_rng) : (|(in_rng & sel));
    assign wr_accept = req_valid && req_write && range_ok;

    prio_store #(
        .DEPTH (SPI_CNT),
        .IDX_W (IDX_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (lane_we),
        .idx   (idx),
        .wdata (st_wd),
        .rdata (st_rd)
    );

    always_comb begin
        if (req_word) begin
            rd_mux = {lane_rd[3], lane_rd[2], lane_rd[1], lane_rd[0]};
        end else begin
            rd_mux = {24'd0, lane_rd[req_addr[1:0]]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            upd_valid <= 1'b0;
            upd_word  <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
            upd_valid <= wr_accept;
            upd_word  <= wr_accept ? req_addr[ADDR_W-1:2] : upd_word;
        end
    end

    // R9: a strobe only ever follows a write request
    a_r9_upd_after_write: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> $past(req_valid && req_write));

    // R10: read data only follows a read request
    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R8: a word write with an illegal lane never strobes
    a_r8_no_partial_word: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_write && req_word && !(&in_rng)) |-> !upd_valid);

    // R5: a restricted byte read always has a clear low bit
    a_r5_ns_lsb_clear: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(restricted && !req_word)) |-> (rsp_rdata[0] == 1'b0));

    // R7: a byte read outside the implemented range returns zero
    a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(!req_word && !(|(in_rng & sel)))) |-> (rsp_rdata == 32'd0));

endmodule

// File: tb/prio_file_bench.sv
`timescale 1ns/1ps
module prio_file_bench;
    localparam int N      = 70;
    localparam int AW     = 10;
    localparam int SPI    = N - 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write, req_word, req_secure, sec_disable;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic [SPI-1:0] grp1_map;
    logic          rsp_valid, upd_valid;
    logic [31:0]   rsp_rdata;
    logic [AW-3:0] upd_word;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [N];

    always #2.5 clk = ~clk;

    prio_file #(.NUM_IRQ(N), .ADDR_W(AW)) u_prio_file (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_secure(req_secure), .req_addr(req_addr),
        .req_wdata(req_wdata), .sec_disable(sec_disable), .grp1_map(grp1_map),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .upd_valid(upd_valid),
        .upd_word(upd_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic in_rng(input int irq);
        return irq >= 32 && irq < N;
    endfunction

    function automatic logic [7:0] exp_byte(input int irq, input logic sec);
        logic r;
        r = !sec && !sec_disable;
        if (!in_rng(irq)) return 8'h00;                 // R7
        if (r && !grp1_map[irq-32]) return 8'h00;       // R4, R11
        if (r) return {model[irq][6:0], 1'b0};          // R5
        return model[irq];                              // R3
    endfunction

    function automatic logic [31:0] exp_read(input logic word, input logic sec, input int addr);
        int b;
        b = addr & ~3;
        if (word) return {exp_byte(b+3, sec), exp_byte(b+2, sec), exp_byte(b+1, sec), exp_byte(b, sec)};
        return {24'd0, exp_byte(addr, sec)};            // R2
    endfunction

    task automatic model_byte(input int irq, input logic sec, input logic [7:0] v);
        logic r;
        r = !sec && !sec_disable;
        if (r && !grp1_map[irq-32]) return;
        model[irq] = r ? {1'b1, v[7:1]} : v;            // R6
    endtask

    // returns 1 when the write passes the range check
    function automatic logic wr_ok(input logic word, input int addr);
        int b;
        b = addr & ~3;
        if (word) return (b >= 32) && (b + 3 < N);      // R8
        return in_rng(addr);
    endfunction

    task automatic op(input logic wr, input logic word, input logic sec,
                      input int addr, input logic [31:0] wd, input string tag);
        logic ok;
        logic [31:0] er;
        int b;
        er = exp_read(word, sec, addr);
        ok = wr && wr_ok(word, addr);
        if (ok) begin
            if (word) begin
                b = addr & ~3;
                for (int l = 0; l < 4; l++) model_byte(b + l, sec, wd[l*8 +: 8]);
            end else begin
                model_byte(addr, sec, wd[7:0]);
            end
        end
        req_valid = 1'b1; req_write = wr; req_word = word; req_secure = sec;
        req_addr = AW'(addr); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            check({tag, " R9 strobe"}, {31'd0, upd_valid}, {31'd0, ok});
            if (ok) check({tag, " R9 word"}, {24'd0, upd_word}, 32'(addr >> 2));
            check({tag, " R10 no rsp"}, {31'd0, rsp_valid}, 32'd0);
        end else begin
            check({tag, " R10 rsp"}, {31'd0, rsp_valid}, 32'd1);
            check({tag, " read"}, rsp_rdata, er);
            check({tag, " R9 no strobe"}, {31'd0, upd_valid}, 32'd0);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) model[i] = 8'h00;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
        req_secure = 1'b0; req_addr = '0; req_wdata = '0; sec_disable = 1'b0;
        grp1_map = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 upd_valid", {31'd0, upd_valid}, 32'd0);
        op(0, 1, 1, 32, 0, "R1 reset word32");
        op(0, 1, 1, 64, 0, "R1 reset word64");

        // secure raw write and lane layout
        op(1, 1, 1, 36, 32'h44332211, "R3 sec word wr");
        op(0, 1, 1, 36, 0, "R2 R3 sec word rd");
        op(0, 0, 1, 38, 0, "R2 byte lane rd");
        op(1, 0, 1, 41, 32'hFFFFFF5A, "R2 byte wr");
        op(0, 1, 1, 40, 0, "R2 byte wr rd");

        // non-secure views
        grp1_map = '0; grp1_map[36-32] = 1'b1; grp1_map[38-32] = 1'b1;
        op(0, 1, 0, 36, 0, "R5 R4 ns word rd");
        op(1, 1, 0, 36, 32'h10203040, "R6 R4 ns word wr");
        op(0, 1, 1, 36, 0, "R6 R4 sec rd after ns wr");
        op(1, 0, 0, 37, 32'h000000AA, "R4 grp0 byte wr strobes");
        op(0, 0, 1, 37, 0, "R4 grp0 unchanged");

        // security disabled: raw for non-secure too
        sec_disable = 1'b1;
        op(1, 0, 0, 37, 32'h00000077, "R3 ds wr");
        op(0, 0, 0, 37, 0, "R3 ds rd");
        sec_disable = 1'b0;

        // range edges
        op(1, 1, 1, 28, 32'hDEADBEEF, "R7 low word wr");
        op(0, 1, 1, 28, 0, "R7 low word rd");
        op(1, 0, 1, 31, 32'h55, "R7 byte 31 wr");
        op(1, 1, 1, 66, 32'h0A0B0C0D, "R8 last full word");
        op(1, 1, 1, 68, 32'h11223344, "R8 straddle word wr");
        op(0, 0, 1, 68, 0, "R8 straddle lane0 rd");
        op(0, 0, 1, 69, 0, "R8 straddle lane1 rd");
        op(1, 0, 1, 69, 32'h9C, "R7 byte 69 wr");
        op(1, 0, 1, 70, 32'h9D, "R7 byte 70 wr");
        op(0, 1, 1, 68, 0, "R7 straddle word rd");

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic wr, wd, sc;
            int a;
            if ((i % 40) == 0) begin
                grp1_map[31:0] = $urandom;
                grp1_map[SPI-1:32] = 6'($urandom);
                sec_disable = ($urandom % 8) == 0;
            end
            wr = $urandom % 2;
            wd = $urandom % 2;
            sc = $urandom % 2;
            a  = 24 + ($urandom % (N - 24 + 8));
            op(wr, wd, sc, a, $urandom, "rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule